// File: doc/BRIEF.md
# GPIO Port with Level Alarms

A parameterised general-purpose I/O port with a per-bit direction and per-bit level alarms, driven over a small command bus. Each cycle the bus carries one opcode and two masks, a set mask and a clear mask. Output values, directions and alarm arming change only through these masks: a bit whose mask bits are both 0 keeps its value. When one command names a bit in both masks, the clear mask wins.

The port drives two vectors to external tri-state pads: the output data (the output shadow register) and an output enable (the direction register). Asynchronous input pins pass through a two-stage synchroniser. The synchronised value is used for both reads and alarm checks. Read commands return either the synchronised pins or the output shadow on a registered read bus. A direction command returns the resulting direction mask on the same bus.

Each bit can be armed for a high alarm, a low alarm, or both. The interrupt output is the OR over all bits whose armed condition holds at the synchronised pin. It stays asserted while that level persists and drops once the bit is disarmed.

Top module: `gpio_alarm_port`

## Requirements
- R1: After reset the output shadow, the direction register (all inputs), both alarm sets and the read bus are all zero, and irq is 0.
- R2: Opcode 1 (output update) drives to 1, on the next clock edge, every output shadow bit whose set-mask bit is 1. Bits with both mask bits 0 keep their value.
- R3: Opcode 1 drives to 0 every output shadow bit whose clear-mask bit is 1, and a bit named in both masks ends at 0.
- R4: Opcode 2 (direction update) makes set-mask bits outputs (1) and clear-mask bits inputs (0), with input winning when a bit is in both masks and unmasked bits unchanged. outEnable shows the direction register and outData shows the output shadow.
- R5: Opcode 2 places the resulting direction mask (1 = output) on rdData at the same edge that updates the direction.
- R6: Opcode 6 (read outputs) places the output shadow on rdData at the next edge, independent of the pin values.
- R7: Opcode 5 (read inputs) places the synchronised pins on rdData at the next edge. A pin change becomes visible there after two clock edges.
- R8: Opcode 3 arms a high alarm on every set-mask bit; irq is 1 while any bit armed high has its synchronised pin at 1.
- R9: Opcode 4 arms a low alarm on every set-mask bit; irq is 1 while any bit armed low has its synchronised pin at 0.
- R10: In opcodes 3 and 4, clear-mask bits are removed from both the high and the low alarm set, winning over the set mask. irq falls at the same edge once no armed condition remains.
- R11: irq follows a pin change after exactly two clock edges, and holds its old value after only one. Opcode 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdOp | input | 3 | Command opcode (0 idle, 1 output, 2 direction, 3 arm high, 4 arm low, 5 read inputs, 6 read outputs) |
| cmdSetMask | input | WIDTH | Bits to set, make output, or arm |
| cmdClrMask | input | WIDTH | Bits to clear, make input, or disarm |
| pinIn | input | WIDTH | Asynchronous pad input values |
| outData | output | WIDTH | Output shadow driven to the pads |
| outEnable | output | WIDTH | Per-bit pad driver enable (1 = output) |
| rdData | output | WIDTH | Registered read result |
| irq | output | 1 | Level alarm interrupt |

## Verification
The bench builds the port with WIDTH = 4. This makes every pair of set and clear masks small enough to sweep exhaustively, for both output and direction commands, including every overlap where the clear must win. At this width every combination of high-armed set, low-armed set and pin pattern can also be enumerated. The bench computes the expected irq for each combination as an OR of masked levels and checks the two-edge synchroniser latency on each pin change.

// File: rtl/gpio_alarm_pkg.sv
package gpio_alarm_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_OUTPUT = 3'd1,
    OP_DIR    = 3'd2,
    OP_ARMHI  = 3'd3,
    OP_ARMLO  = 3'd4,
    OP_RDIN   = 3'd5,
    OP_RDOUT  = 3'd6
  } gpioOp_e;

  typedef struct packed {
    logic doOut;
    logic doDir;
    logic armHi;
    logic armLo;
    logic rdIn;
    logic rdOut;
  } gpioStrb_t;

endpackage

// File: rtl/gpio_alarm_ctrl.sv
module gpio_alarm_ctrl
  import gpio_alarm_pkg::*;
(
  input  logic      [2:0] cmdOp,
  output gpioStrb_t       strb
);

  always_comb begin
    strb = '0;
    unique case (cmdOp)
      OP_OUTPUT: strb.doOut = 1'b1;
      OP_DIR:    strb.doDir = 1'b1;
      OP_ARMHI:  strb.armHi = 1'b1;
      OP_ARMLO:  strb.armLo = 1'b1;
      OP_RDIN:   strb.rdIn  = 1'b1;
      OP_RDOUT:  strb.rdOut = 1'b1;
      default:   strb = '0;
    endcase
  end

endmodule

// File: rtl/gpio_alarm_dp.sv
module gpio_alarm_dp
  import gpio_alarm_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpioStrb_t        strb,
  input  logic [WIDTH-1:0] setMask,
  input  logic [WIDTH-1:0] clrMask,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] outData,
  output logic [WIDTH-1:0] outEnable,
  output logic [WIDTH-1:0] rdData,
  output logic             irq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncQ;
  logic [WIDTH-1:0] syncIn;
  logic [WIDTH-1:0] shadowQ, dirQ, hiArmQ, loArmQ;
  logic [WIDTH-1:0] shadowNext, dirNext, hiArmNext, loArmNext, rdNext;
  logic [WIDTH-1:0] hitVec;

  // Input synchroniser chain
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ[0] <= pinIn;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  assign syncIn = syncQ[LAST];

  // Next-state logic: clear mask always applied after set mask
  always_comb begin
    shadowNext = shadowQ;
    dirNext    = dirQ;
    hiArmNext  = hiArmQ;
    loArmNext  = loArmQ;
    if (strb.doOut) shadowNext = (shadowQ | setMask) & ~clrMask;
    if (strb.doDir) dirNext    = (dirQ | setMask) & ~clrMask;
    if (strb.armHi || strb.armLo) begin
      hiArmNext = (hiArmQ | (strb.armHi ? setMask : '0)) & ~clrMask;
      loArmNext = (loArmQ | (strb.armLo ? setMask : '0)) & ~clrMask;
    end
  end

  always_comb begin
    rdNext = rdData;
    if (strb.rdIn)       rdNext = syncIn;
    else if (strb.rdOut) rdNext = shadowQ;
    else if (strb.doDir) rdNext = dirNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
      dirQ    <= '0;
      hiArmQ  <= '0;
      loArmQ  <= '0;
      rdData  <= '0;
    end else begin
      shadowQ <= shadowNext;
      dirQ    <= dirNext;
      hiArmQ  <= hiArmNext;
      loArmQ  <= loArmNext;
      rdData  <= rdNext;
    end
  end

  assign hitVec    = (hiArmQ & syncIn) | (loArmQ & ~syncIn);
  assign irq       = |hitVec;
  assign outData   = shadowQ;
  assign outEnable = dirQ;

  // R2
  out_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doOut |=> ((outData & $past(setMask & ~clrMask)) == $past(setMask & ~clrMask)));

  // R3
  out_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doOut |=> ((outData & $past(clrMask)) == '0));

  // R2
  out_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doOut |=> ((outData & ~$past(setMask | clrMask)) == ($past(outData) & ~$past(setMask | clrMask))));

  // R4
  dir_input_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doDir |=> ((outEnable & $past(clrMask)) == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> ($stable(outData) && $stable(outEnable) && $stable(rdData)));

  // R10
  disarm_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.armHi || strb.armLo) && (&clrMask)) |=> !irq);

  // R5
  rd_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdIn, strb.rdOut, strb.doDir, strb.doOut, strb.armHi, strb.armLo}));

endmodule

// File: rtl/gpio_alarm_port.sv
module gpio_alarm_port
  import gpio_alarm_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmdOp,
  input  logic [WIDTH-1:0] cmdSetMask,
  input  logic [WIDTH-1:0] cmdClrMask,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] outData,
  output logic [WIDTH-1:0] outEnable,
  output logic [WIDTH-1:0] rdData,
  output logic             irq
);

  gpioStrb_t strb;

  gpio_alarm_ctrl i_ctrl (
    .cmdOp (cmdOp),
    .strb  (strb)
  );

  gpio_alarm_dp #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .setMask   (cmdSetMask),
    .clrMask   (cmdClrMask),
    .pinIn     (pinIn),
    .outData   (outData),
    .outEnable (outEnable),
    .rdData    (rdData),
    .irq       (irq)
  );

endmodule

// File: tb/test_gpio_alarm_port.sv
module test_gpio_alarm_port;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   cmdOp = 3'd0;
  logic [W-1:0] cmdSetMask = '0;
  logic [W-1:0] cmdClrMask = '0;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] outData, outEnable, rdData;
  logic         irq;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] mOut = '0, mDir = '0, mHi = '0, mLo = '0;

  always #2 clk = ~clk;

  gpio_alarm_port #(.WIDTH(W)) i_gpio_alarm_port (
    .clk, .rstN, .cmdOp, .cmdSetMask, .cmdClrMask, .pinIn,
    .outData, .outEnable, .rdData, .irq
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [W-1:0] s, input logic [W-1:0] c);
    @(negedge clk);
    cmdOp = op; cmdSetMask = s; cmdClrMask = c;
    @(negedge clk);
    cmdOp = 3'd0; cmdSetMask = '0; cmdClrMask = '0;
  endtask

  function automatic logic expIrq(input logic [W-1:0] p);
    return |((mHi & p) | (mLo & ~p));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outData", outData, 0);
    check("R1 outEnable", outEnable, 0);
    check("R1 rdData", rdData, 0);
    check("R1 irq", irq, 0);

    // R2 R3 exhaustive output update sweep
    for (int s = 0; s < N; s++) begin
      for (int c = 0; c < N; c++) begin
        cmd(3'd1, W'(s), W'(c));
        mOut = (mOut | W'(s)) & ~W'(c);
        check("R2_R3 output update", outData, mOut);
      end
    end

    // R6 read outputs returns shadow, not pins
    cmd(3'd1, W'(4'b1010), W'(4'b0101));
    mOut = W'(4'b1010);
    pinIn = ~mOut;
    repeat (3) @(negedge clk);
    cmd(3'd6, '0, '0);
    check("R6 read outputs", rdData, mOut);

    // R4 R5 exhaustive direction sweep
    for (int s = 0; s < N; s++) begin
      for (int c = 0; c < N; c++) begin
        cmd(3'd2, W'(s), W'(c));
        mDir = (mDir | W'(s)) & ~W'(c);
        check("R4 direction", outEnable, mDir);
        check("R5 direction readback", rdData, mDir);
      end
    end
    check("R4 outData unchanged", outData, mOut);

    // R11 idle op changes nothing
    cmd(3'd0, W'(4'b1111), W'(4'b1111));
    check("R11 idle keeps outData", outData, mOut);
    check("R11 idle keeps outEnable", outEnable, mDir);

    // R7 R8 R9 R11 alarm sweep over high set, low set and pins
    for (int h = 0; h < N; h++) begin
      for (int l = 0; l < N; l++) begin
        cmd(3'd3, '0, W'(N - 1));
        mHi = '0; mLo = '0;
        cmd(3'd3, W'(h), '0);
        mHi = W'(h);
        cmd(3'd4, W'(l), '0);
        mLo = W'(l);
        check("R8_R9 armed irq", irq, expIrq(pinIn));
        for (int p = 0; p < N; p++) begin
          logic [W-1:0] oldPin;
          oldPin = pinIn;
          @(negedge clk);
          pinIn = W'(p);
          @(negedge clk);
          check("R11 one edge holds", irq, expIrq(oldPin));
          @(negedge clk);
          check("R8_R9 irq level", irq, expIrq(W'(p)));
          if (h == 0 && l == 0) begin
            cmd(3'd5, '0, '0);
            check("R7 read inputs", rdData, p);
          end
        end
      end
    end

    // R10 disarm clears both sets and irq falls
    cmd(3'd3, W'(4'b0011), '0);
    mHi = mHi | W'(4'b0011);
    cmd(3'd4, W'(4'b1100), '0);
    mLo = mLo | W'(4'b1100);
    pinIn = W'(4'b0001);
    repeat (2) @(negedge clk);
    check("R10 irq before disarm", irq, expIrq(pinIn));
    cmd(3'd4, W'(4'b1111), W'(4'b1111));
    mHi = '0; mLo = '0;
    check("R10 irq after disarm", irq, 0);
    pinIn = W'(4'b0000);
    repeat (2) @(negedge clk);
    check("R10 low set disarmed too", irq, 0);
    pinIn = W'(4'b1111);
    repeat (2) @(negedge clk);
    check("R10 high set disarmed too", irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule